// File: doc/BRIEF.md
# Banked Pin Controller

This block drives and samples sixteen general-purpose pins through a small 32-bit register bus. The pins are grouped into four banks of unequal width: two, four, four and six pins. Each bank has one register that holds output levels and returns input levels. It also has one register of 4-bit mode codes, one code per pin. A single shared register chooses, for each pin, between an actively driven pad and an open-drain pad that only pulls low.

Software writes a mode code to set a pin up. Code 0x1 makes it an input and code 0x8 makes it an output; any other code leaves the pin undriven. The bus read port is combinational on the address. Writes take effect at the clock edge on which the write enable is high. Incoming pin levels pass through a two-flop synchroniser before a register read can see them.

Top module: `bankio_top`

## Requirements
- R1: After reset every data, mode and drive bit is zero, so every register reads zero and padOe and padOut are all low.
- R2: The bank data registers sit at byte offsets 0x170, 0x174, 0x178 and 0x17C, for banks 0 to 3. Write bit n stores the level for pin n of that bank. Bits at or above the bank's pin count read zero and ignore writes.
- R3: The bank mode registers sit at 0x180, 0x184, 0x188 and 0x18C. Pin n of the bank owns bits [4n+3:4n]. Any 4-bit code reads back unchanged, and nibbles beyond the bank's pin count read zero.
- R4: A pin with mode 0x8 and drive bit 0 has padOe high and padOut equal to its data bit. A write appears on the pads right after the clock edge that takes the write.
- R5: For a pin with mode 0x1, padOe is low, and reading its data bit returns the pad level through two flops. A change at padIn is invisible after one rising edge and visible after the second. The stored data bit is not returned for such a pin.
- R6: A pin whose mode is neither 0x1 nor 0x8 has padOe low. Reading its data bit returns the stored bit.
- R7: The drive register at 0x190 holds one bit per global pin in bits 15:0; upper bits read zero. With the bit set, an output pin with data 1 has padOe low, and with data 0 it has padOe high and padOut low.
- R8: Reads from any other address return zero. Writes to them change no register and no pad.
- R9: Bank 0 maps to pins 0-1, bank 1 to pins 2-5, bank 2 to pins 6-9 and bank 3 to pins 10-15. Bit n of a bank register refers to the bank's first pin plus n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address of the register access |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 16 | Asynchronous pin levels |
| padOut | output | 16 | Level to drive on each pin |
| padOe | output | 16 | Drive enable for each pin |

## Verification
The output-level path and the drive-mode path act on the same pad in the same cycle. A data write that changes an open-drain pin's level must move padOe, not padOut, on the edge right after the write. The bench provokes this by writing data to bank 1 while pin 3 is marked open-drain. Its pad expectation is queued for that same edge, so it is judged against both registers at once. A second such meeting is the synchroniser and the mode decode: a pin is switched from input to output while its neighbours' sampled levels are still being read through the same register.

// File: rtl/bankio_pkg.sv
package bankio_pkg;

  localparam int BANKS = 4;
  localparam int PINS  = 16;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_IN  = 4'h1;
  localparam logic [MODE_W-1:0] MODE_OUT = 4'h8;

  function automatic int bankSize(input int b);
    case (b)
      0: return 2;
      1: return 4;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int bankFirst(input int b);
    int s;
    s = 0;
    for (int i = 0; i < b; i++) s += bankSize(i);
    return s;
  endfunction

  typedef struct packed {
    logic             we;
    logic [BANKS-1:0] dataHit;
    logic [BANKS-1:0] cfgHit;
    logic             driveHit;
  } busStrobe_t;

endpackage

// File: rtl/bankio_ctrl.sv
module bankio_ctrl
  import bankio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'h170,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 12'h180,
  parameter logic [ADDR_W-1:0] DRIVE_OFS = 12'h190
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strb
);

  logic [BANKS-1:0] dataHit;
  logic [BANKS-1:0] cfgHit;

  for (genvar b = 0; b < BANKS; b++) begin : gDecode
    localparam logic [ADDR_W-1:0] DATA_ADDR = DATA_BASE + ADDR_W'(4 * b);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = CFG_BASE + ADDR_W'(4 * b);
    assign dataHit[b] = (busAddr == DATA_ADDR);
    assign cfgHit[b]  = (busAddr == CFG_ADDR);
  end

  always_comb begin
    strb.we       = busWe;
    strb.dataHit  = dataHit;
    strb.cfgHit   = cfgHit;
    strb.driveHit = (busAddr == DRIVE_OFS);
  end

  // R8: an address selects at most one register
  always_comb begin
    assert_single_target_R8: assert ($onehot0({dataHit, cfgHit, strb.driveHit}));
  end

endmodule

// File: rtl/bankio_dp.sv
module bankio_dp
  import bankio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);

  logic [PINS-1:0]             outBit, nextOut;
  logic [PINS-1:0][MODE_W-1:0] modeReg, nextMode;
  logic [PINS-1:0]             odReg, nextOd;
  logic [PINS-1:0]             syncA, syncB;
  logic [PINS-1:0]             pinRd;
  logic [BANKS-1:0][DATA_W-1:0] bankData;
  logic [BANKS-1:0][DATA_W-1:0] bankCfg;

  // Per-bank write steering and readback assembly
  for (genvar b = 0; b < BANKS; b++) begin : gBank
    localparam int SZ    = bankSize(b);
    localparam int FIRST = bankFirst(b);

    for (genvar n = 0; n < SZ; n++) begin : gPin
      localparam int G = FIRST + n;
      assign nextOut[G]  = (strb.we && strb.dataHit[b]) ? busWdata[n] : outBit[G];
      assign nextMode[G] = (strb.we && strb.cfgHit[b]) ? busWdata[MODE_W*n +: MODE_W]
                                                       : modeReg[G];
      assign bankData[b][n] = pinRd[G];
      assign bankCfg[b][MODE_W*n +: MODE_W] = modeReg[G];
    end

    if (SZ < DATA_W) begin : gDataPad
      assign bankData[b][DATA_W-1:SZ] = '0;
    end
    if (MODE_W * SZ < DATA_W) begin : gCfgPad
      assign bankCfg[b][DATA_W-1:MODE_W*SZ] = '0;
    end

    // R2: a data write lands in exactly the bank's pins
    assert_data_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.we && strb.dataHit[b]) |=> (outBit[FIRST +: SZ] == $past(busWdata[SZ-1:0])));
  end

  assign nextOd = (strb.we && strb.driveHit) ? busWdata[PINS-1:0] : odReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit  <= '0;
      modeReg <= '0;
      odReg   <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      outBit  <= nextOut;
      modeReg <= nextMode;
      odReg   <= nextOd;
      syncA   <= padIn;
      syncB   <= syncA;
    end
  end

  // Direction-dependent readback per pin
  always_comb begin
    for (int g = 0; g < PINS; g++) begin
      pinRd[g] = (modeReg[g] == MODE_IN) ? syncB[g] : outBit[g];
    end
  end

  // Pad drive with open-drain gating
  always_comb begin
    for (int g = 0; g < PINS; g++) begin
      padOe[g]  = 1'b0;
      padOut[g] = 1'b0;
      if (modeReg[g] == MODE_OUT) begin
        if (odReg[g]) begin
          padOe[g] = ~outBit[g];
        end else begin
          padOe[g]  = 1'b1;
          padOut[g] = outBit[g];
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (strb.dataHit[b]) busRdata |= bankData[b];
      if (strb.cfgHit[b])  busRdata |= bankCfg[b];
    end
    if (strb.driveHit) busRdata |= DATA_W'(odReg);
  end

  // R1: reset clears every register
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rstN |=> (outBit == '0 && modeReg == '0 && odReg == '0));

  // R7: an open-drain pin never drives high
  assert_od_no_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(|(padOe & odReg & padOut)));

  // R8: writes outside the map leave all state alone
  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.we && !(|{strb.dataHit, strb.cfgHit, strb.driveHit}))
      |=> ($stable(outBit) && $stable(modeReg) && $stable(odReg)));

endmodule

// File: rtl/bankio_top.sv
module bankio_top
  import bankio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'h170,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 12'h180,
  parameter logic [ADDR_W-1:0] DRIVE_OFS = 12'h190
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [15:0]       padIn,
  output logic [15:0]       padOut,
  output logic [15:0]       padOe
);

  busStrobe_t strb;

  bankio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .CFG_BASE(CFG_BASE), .DRIVE_OFS(DRIVE_OFS)
  ) uCtrl (
    .busAddr(busAddr),
    .busWe(busWe),
    .strb(strb)
  );

  bankio_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn(padIn),
    .padOut(padOut),
    .padOe(padOe)
  );

endmodule

// File: tb/sim_bankio_top.sv
module sim_bankio_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    bit          isPin;
    logic [31:0] expRd;
    logic [15:0] expOe;
    logic [15:0] expOut;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;

  item_t sbQueue[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankio_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // Monitor: one expected item is judged just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        item_t it;
        it = sbQueue.pop_front();
        total++;
        if (it.isPin) begin
          if (padOe !== it.expOe || padOut !== it.expOut) begin
            bad++;
            $display("FAIL %s: oe=%h out=%h expected oe=%h out=%h",
                     it.tag, padOe, padOut, it.expOe, it.expOut);
          end
        end else if (busRdata !== it.expRd) begin
          bad++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, busRdata, it.expRd);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic wrPins(input logic [11:0] a, input logic [31:0] d,
                        input logic [15:0] oe, input logic [15:0] out, input string tag);
    item_t it;
    it.isPin = 1'b1; it.expRd = '0; it.expOe = oe; it.expOut = out; it.tag = tag;
    busAddr = a; busWe = 1'b1; busWdata = d;
    sbQueue.push_back(it);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.isPin = 1'b0; it.expRd = exp; it.expOe = '0; it.expOut = '0; it.tag = tag;
    busAddr = a; busWe = 1'b0;
    sbQueue.push_back(it);
    @(negedge clk);
  endtask

  task automatic pins(input logic [15:0] oe, input logic [15:0] out, input string tag);
    item_t it;
    it.isPin = 1'b1; it.expRd = '0; it.expOe = oe; it.expOut = out; it.tag = tag;
    sbQueue.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h170, 32'h0, "R1 bank0 data");
    rd(12'h184, 32'h0, "R1 bank1 mode");
    rd(12'h190, 32'h0, "R1 drive");
    pins(16'h0, 16'h0, "R1 pads idle");

    // R2 data registers, unused bits
    wr(12'h170, 32'hFFFF_FFFF);
    rd(12'h170, 32'h0000_0003, "R2 bank0 width");
    wr(12'h17C, 32'hFFFF_FFFF);
    rd(12'h17C, 32'h0000_003F, "R2 bank3 width");
    wr(12'h174, 32'h0000_000A);
    rd(12'h174, 32'h0000_000A, "R2 bank1 pattern");

    // R3 mode nibbles, arbitrary codes kept
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, 32'h0000_00FF, "R3 bank0 nibbles");
    wr(12'h18C, 32'hDEAD_BEEF);
    rd(12'h18C, 32'h00AD_BEEF, "R3 bank3 nibbles");
    wr(12'h184, 32'h1234_5678);
    rd(12'h184, 32'h0000_5678, "R3 bank1 nibbles");

    // R4/R9 bank1 all outputs -> global pins 2..5, data 0xA -> pins 3,5
    wrPins(12'h184, 32'h0000_8888, 16'h003C, 16'h0028, "R4 R9 push-pull after write");

    // R6 odd codes leave pins 2 and 4 undriven
    wrPins(12'h184, 32'h0000_8F8A, 16'h0028, 16'h0028, "R6 undriven codes");
    rd(12'h174, 32'h0000_000A, "R6 stored data readback");

    // R7 open-drain on pin 3; upper bits dropped
    wrPins(12'h190, 32'hFFFF_0008, 16'h0020, 16'h0020, "R7 od high released");
    rd(12'h190, 32'h0000_0008, "R7 drive readback");
    wrPins(12'h174, 32'h0000_0008, 16'h0028, 16'h0020, "R7 od low driven");

    // R8 unmapped accesses
    wr(12'h1A0, 32'hFFFF_FFFF);
    wr(12'h172, 32'hFFFF_FFFF);
    rd(12'h1A0, 32'h0, "R8 unmapped read");
    rd(12'h100, 32'h0, "R8 low unmapped read");
    rd(12'h174, 32'h0000_0008, "R8 data untouched");
    rd(12'h190, 32'h0000_0008, "R8 drive untouched");
    pins(16'h0028, 16'h0020, "R8 pads untouched");

    // R5 inputs on bank2 (pins 6..9)
    wr(12'h188, 32'h0000_1111);
    wr(12'h178, 32'h0000_000F);
    rd(12'h178, 32'h0, "R5 stored bits hidden");
    padIn = 16'h0200;
    rd(12'h178, 32'h0, "R5 one edge not yet");
    rd(12'h178, 32'h0000_0008, "R5 two edges visible");
    pins(16'h0028, 16'h0020, "R5 inputs undriven");

    // R4 pin 6 switched to output while pin 9 is still sampled
    wrPins(12'h188, 32'h0000_1118, 16'h0068, 16'h0060, "R4 R9 bank2 pin output");
    rd(12'h178, 32'h0000_0009, "R5 mixed readback");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R1..: run did not finish, got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule